// File: doc/BRIEF.md
# Eight-Pin I/O Port with Per-Pin Function Routing

This block controls an eight-pin I/O port. Every pin has its own two-bit function code. The code hands the pad either to plain software-driven I/O or to one of three peripheral paths: an analog converter, a timer or a serial controller. Software uses a small word-wide register file to set each pin's function, direction, output level, pull control and interrupt behaviour. It also reads back the synchronized pin levels and the latched edge events.

Pad inputs pass through a two-flop synchronizer. The synchronized levels serve three purposes: they feed the input register, they go to whichever peripheral owns the pin, and they drive a per-pin edge detector. The detector watches for a rising or a falling edge, as selected for that pin, and latches a sticky flag when it sees one. One interrupt line combines every flag whose enable bit is set. The pads, the pull resistors and the peripherals themselves sit outside this block. It only produces their control signals.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every register reads 0, no pad is driven (`pad_oe_o` = 0) and `irq_o` is low.
- R2: Register addresses: 0 function low plane, 1 function high plane, 2 direction, 3 output, 4 input (read only), 5 pull enable, 6 interrupt enable, 7 interrupt flags, 8 edge select. Writable registers read back the value last written. Writes to address 4 have no effect.
- R3: A pin's function code is {high plane bit, low plane bit}: 00 plain I/O, 01 analog, 10 timer, 11 serial.
- R4: In plain I/O mode the pad is driven with the output register bit when the direction bit is 1. It is undriven when the direction bit is 0.
- R5: In analog mode the pad is undriven with output 0, and `adc_sel_o` is 1 for that pin. It is 0 for pins in any other mode.
- R6: In timer or serial mode, the pad output value and output enable come from that peripheral's inputs. The pin's synchronized level appears on that peripheral's input line, and that input line reads 0 for pins routed elsewhere.
- R7: The input register shows a pad level change two clock edges after the change is sampled.
- R8: `pull_en_o` is set only for a plain I/O pin whose direction is input and whose pull bit is 1. In that case `pull_up_o` equals the output register bit (1 pull-up, 0 pull-down). Otherwise both are 0.
- R9: An edge select bit of 0 latches a rising edge and a bit of 1 latches a falling edge. The flag is set on the third clock edge after the pad changes.
- R10: A flag stays set until software writes 0 to that bit. Writing 1 leaves the bit unchanged. An edge in the same cycle as a clearing write keeps the flag set.
- R11: `irq_o` is the OR over all pins of flag AND interrupt enable. A flag without its enable does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pad_in_i | input | 8 | Raw pad levels |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pull_en_o | output | 8 | Pull resistor enable |
| pull_up_o | output | 8 | Pull direction, 1 = up |
| adc_sel_o | output | 8 | Pin routed to the analog converter |
| tmr_out_i | input | 8 | Timer output value per pin |
| tmr_oe_i | input | 8 | Timer output enable per pin |
| tmr_in_o | output | 8 | Synchronized level to the timer |
| ser_out_i | input | 8 | Serial output value per pin |
| ser_oe_i | input | 8 | Serial output enable per pin |
| ser_in_o | output | 8 | Synchronized level to the serial controller |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The edge properties assume that pad inputs are low while reset is held. The synchronizer and the previous-sample register reset to 0, so a pad that is high at release would look like a genuine rising edge. The stimulus therefore holds every pad at 0 through reset and changes pads only at falling clock edges. Register writes are single-cycle strobes, timed against pad changes so that one write lands in exactly the cycle in which an edge is latched.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_ADC  = 2'b01,
    FN_TMR  = 2'b10,
    FN_SER  = 2'b11
  } pin_fn_e;

  localparam logic [ADDR_W-1:0] A_FN_LO  = 4'd0;
  localparam logic [ADDR_W-1:0] A_FN_HI  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIR    = 4'd2;
  localparam logic [ADDR_W-1:0] A_OUT    = 4'd3;
  localparam logic [ADDR_W-1:0] A_IN     = 4'd4;
  localparam logic [ADDR_W-1:0] A_PULL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_IE     = 4'd6;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd7;
  localparam logic [ADDR_W-1:0] A_EDGE   = 4'd8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
(
  input  pin_fn_e fn_i,
  input  logic    dir_i,
  input  logic    out_i,
  input  logic    pull_i,
  input  logic    level_i,
  input  logic    tmr_out_i,
  input  logic    tmr_oe_i,
  input  logic    ser_out_i,
  input  logic    ser_oe_i,
  output logic    pad_out_o,
  output logic    pad_oe_o,
  output logic    pull_en_o,
  output logic    pull_up_o,
  output logic    adc_sel_o,
  output logic    tmr_in_o,
  output logic    ser_in_o
);
  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    pull_en_o = 1'b0;
    pull_up_o = 1'b0;
    adc_sel_o = 1'b0;
    tmr_in_o  = 1'b0;
    ser_in_o  = 1'b0;
    unique case (fn_i)
      FN_GPIO: begin
        pad_oe_o  = dir_i;
        pad_out_o = dir_i & out_i;
        pull_en_o = ~dir_i & pull_i;
        pull_up_o = ~dir_i & pull_i & out_i;
      end
      FN_ADC: adc_sel_o = 1'b1;
      FN_TMR: begin
        pad_oe_o  = tmr_oe_i;
        pad_out_o = tmr_out_i;
        tmr_in_o  = level_i;
      end
      FN_SER: begin
        pad_oe_o  = ser_oe_i;
        pad_out_o = ser_out_i;
        ser_in_o  = level_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] edge_sel_i,
  input  logic [W-1:0] ie_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] flag_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, flag_q, flag_d, hit;

  // level differs from last sample and matches the wanted polarity
  assign hit = (level_i ^ prev_q) & (level_i ^ edge_sel_i);

  always_comb begin
    flag_d = clr_we_i ? (flag_q & clr_data_i) : flag_q;
    flag_d = flag_d | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ie_i);

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r9_flag_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(level_i[i] != edge_sel_i[i]) && $past(level_i[i] != prev_q[i]));
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !(clr_we_i && !clr_data_i[i])) |=> flag_q[i]);
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] adc_sel_o,
  input  logic [NUM_PINS-1:0] tmr_out_i,
  input  logic [NUM_PINS-1:0] tmr_oe_i,
  output logic [NUM_PINS-1:0] tmr_in_o,
  input  logic [NUM_PINS-1:0] ser_out_i,
  input  logic [NUM_PINS-1:0] ser_oe_i,
  output logic [NUM_PINS-1:0] ser_in_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] fn_lo_q, fn_hi_q, dir_q, out_q, pull_q, ie_q, edge_q;
  logic [NUM_PINS-1:0] level, flag;
  logic                flag_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_lo_q <= '0;
      fn_hi_q <= '0;
      dir_q   <= '0;
      out_q   <= '0;
      pull_q  <= '0;
      ie_q    <= '0;
      edge_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_FN_LO: fn_lo_q <= wdata_i;
        A_FN_HI: fn_hi_q <= wdata_i;
        A_DIR:   dir_q   <= wdata_i;
        A_OUT:   out_q   <= wdata_i;
        A_PULL:  pull_q  <= wdata_i;
        A_IE:    ie_q    <= wdata_i;
        A_EDGE:  edge_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_FN_LO: rdata_o = fn_lo_q;
      A_FN_HI: rdata_o = fn_hi_q;
      A_DIR:   rdata_o = dir_q;
      A_OUT:   rdata_o = out_q;
      A_IN:    rdata_o = level;
      A_PULL:  rdata_o = pull_q;
      A_IE:    rdata_o = ie_q;
      A_FLAG:  rdata_o = flag;
      A_EDGE:  rdata_o = edge_q;
      default: rdata_o = '0;
    endcase
  end

  assign flag_we = wr_en_i && (addr_i == A_FLAG);

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (level)
  );

  gpio_irq #(.W(NUM_PINS)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .edge_sel_i(edge_q),
    .ie_i      (ie_q),
    .clr_we_i  (flag_we),
    .clr_data_i(wdata_i),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_fn_e fn;
    assign fn = pin_fn_e'({fn_hi_q[i], fn_lo_q[i]});

    gpio_pin_mux u_mux (
      .fn_i     (fn),
      .dir_i    (dir_q[i]),
      .out_i    (out_q[i]),
      .pull_i   (pull_q[i]),
      .level_i  (level[i]),
      .tmr_out_i(tmr_out_i[i]),
      .tmr_oe_i (tmr_oe_i[i]),
      .ser_out_i(ser_out_i[i]),
      .ser_oe_i (ser_oe_i[i]),
      .pad_out_o(pad_out_o[i]),
      .pad_oe_o (pad_oe_o[i]),
      .pull_en_o(pull_en_o[i]),
      .pull_up_o(pull_up_o[i]),
      .adc_sel_o(adc_sel_o[i]),
      .tmr_in_o (tmr_in_o[i]),
      .ser_in_o (ser_in_o[i])
    );

    a_r5_analog_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fn == FN_ADC) |-> (!pad_oe_o[i] && !pad_out_o[i] && !pull_en_o[i]));
  end

  a_r8_no_pull_on_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pad_oe_o) == '0);
  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_q != '0));
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pad_oe_o == '0) && !irq_o);
endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pull_en, pull_up, adc_sel, tmr_in, ser_in;
  logic [7:0] tmr_out = '0, tmr_oe = '0, ser_out = '0, ser_oe = '0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  gpio_mux_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pull_en_o(pull_en), .pull_up_o(pull_up), .adc_sel_o(adc_sel),
    .tmr_out_i(tmr_out), .tmr_oe_i(tmr_oe), .tmr_in_o(tmr_in),
    .ser_out_i(ser_out), .ser_oe_i(ser_oe), .ser_in_o(ser_in), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_cfg();
    for (int a = 0; a < 9; a++) if (a != 4) wr(a[3:0], 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], v);
      chk("R1 reg zero", v, 8'h00);
    end
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(4'd0, 8'h3C); wr(4'd2, 8'h5A); wr(4'd5, 8'hC3); wr(4'd8, 8'h96);
    rd(4'd0, v); chk("R2 fn_lo", v, 8'h3C);
    rd(4'd2, v); chk("R2 dir", v, 8'h5A);
    rd(4'd5, v); chk("R2 pull", v, 8'hC3);
    rd(4'd8, v); chk("R2 edge", v, 8'h96);
    wr(4'd4, 8'hFF);
    rd(4'd4, v); chk("R2 input read only", v, 8'h00);
    clear_cfg();
  endtask

  task automatic t_gpio_drive();
    wr(4'd2, 8'h0F); wr(4'd3, 8'hA5);
    chk("R4 oe", pad_oe, 8'h0F);
    chk("R4 out", pad_out, 8'h05);
    clear_cfg();
  endtask

  task automatic t_fn_select();
    // pins 0,1 plain; 2,3 analog; 4,5 timer; 6,7 serial
    wr(4'd0, 8'hCC); wr(4'd1, 8'hF0); wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    tmr_out = 8'hFF; tmr_oe = 8'h10; ser_out = 8'h40; ser_oe = 8'hC0;
    #1;
    chk("R3 R6 oe routing", pad_oe, 8'hD3);
    chk("R5 R6 out routing", pad_out, 8'h73);
    chk("R5 adc_sel", adc_sel, 8'h0C);
    pad_in = 8'hFF;
    step(2);
    chk("R6 timer input", tmr_in, 8'h30);
    chk("R6 serial input", ser_in, 8'hC0);
    tmr_out = '0; tmr_oe = '0; ser_out = '0; ser_oe = '0;
    pad_in = 8'h00;
    step(4);
    clear_cfg();
  endtask

  task automatic t_sync();
    logic [7:0] v;
    pad_in = 8'h81;
    step(1); rd(4'd4, v); chk("R7 not yet", v, 8'h00);
    step(1); rd(4'd4, v); chk("R7 visible", v, 8'h81);
    pad_in = 8'h00;
    step(4);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_pull();
    wr(4'd2, 8'h0F); wr(4'd5, 8'hFF); wr(4'd3, 8'h30);
    chk("R8 pull_en", pull_en, 8'hF0);
    chk("R8 pull_up", pull_up, 8'h30);
    wr(4'd1, 8'h80);
    chk("R8 pull off alt", pull_en, 8'h70);
    clear_cfg();
  endtask

  task automatic t_edge();
    logic [7:0] v;
    wr(4'd8, 8'h0F);
    pad_in = 8'hFF;
    step(2); rd(4'd7, v); chk("R9 not yet", v, 8'h00);
    step(1); rd(4'd7, v); chk("R9 rising", v, 8'hF0);
    chk("R11 no enable no irq", {7'd0, irq}, 8'h00);
    pad_in = 8'h00;
    step(3); rd(4'd7, v); chk("R9 falling", v, 8'hFF);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(4'd7, 8'h0F);
    rd(4'd7, v); chk("R10 partial clear", v, 8'h0F);
    pad_in = 8'h10;
    step(2);
    wr(4'd7, 8'h00);
    rd(4'd7, v); chk("R10 set wins", v, 8'h10);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(4'd6, 8'h01);
    chk("R11 masked", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'h10);
    chk("R11 raised", {7'd0, irq}, 8'h01);
    wr(4'd7, 8'h00);
    rd(4'd7, v);
    chk("R11 cleared flags", v, 8'h00);
    chk("R11 dropped", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_gpio_drive();
    t_fn_select();
    t_sync();
    t_pull();
    t_edge();
    t_clear();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule